// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply-accumulate engine of a 32-bit processor core. It keeps a 64-bit signed accumulator as two 32-bit words, upper and lower. On a start strobe it captures two operands, an operation select and a saturation-mode bit. It then forms a signed product, adds the product to the accumulator and writes the sum back a fixed number of clock edges later. A one-cycle done pulse marks the write-back.

Two operations are offered. The long operation multiplies the full 32-bit operands. The word operation multiplies only their low halves. Each operation treats an overflow in its own way when saturation is on. The long form clamps the upper word to a 48-bit signed window. The word form pins the sum to the 32-bit signed limits and marks the event by writing 1 into the upper word. Software can zero the accumulator, or set either word directly, through a clear input and two write ports.

Top module: `mac_unit`

## Requirements
- R1: While reset is held and just after it, both accumulator words read 0 and done_o is low.
- R2: With op_word_i = 0 (long) and sat_i = 0, the new 64-bit accumulator is the old one plus the signed 32x32 product of a_i and b_i, modulo 2^64, with the upper word in acc_hi_o and the lower word in acc_lo_o.
- R3: With op_word_i = 1 (word) and sat_i = 0, only bits 15:0 of each operand are used, as signed 16-bit values; their product is sign-extended and added to the 64-bit accumulator, modulo 2^64.
- R4: Long with sat_i = 1: the lower word takes the low 32 bits of the 64-bit sum. If the sum is negative, the upper word becomes the sum's upper 32 bits ORed with 0xFFFF0000; otherwise it becomes those bits ANDed with 0x00007FFF.
- R5: Word with sat_i = 1: a sum below -2^31 gives upper word 1 and lower word 0x80000000. A sum above 2^31-1 gives upper word 1 and lower word 0x7FFFFFFF. Any other sum is stored unchanged.
- R6: The accumulator is written at clock edge E+LAT, where E is the edge that accepts start_i and LAT is the latency parameter (default 3). done_o is high for exactly the one cycle that follows that edge and is low at all other times.
- R7: A start_i that arrives while an operation is in flight is ignored, including in the cycle of its write-back. It neither changes the operands in use nor causes a second done pulse.
- R8: clr_i zeroes both words at the next edge. It wins over the write ports and over a write-back in the same cycle, and done_o still pulses for that write-back.
- R9: hi_we_i and lo_we_i each load only their own word at the next edge. If a write coincides with a write-back, the written word takes the port data and the other word takes the result.
- R10: The sum is formed from the accumulator contents in the write-back cycle, so a load made while an operation is in flight is included in its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_word_i | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| sat_i | input | 1 | 1 = saturating accumulation |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| clr_i | input | 1 | Zero both accumulator words |
| hi_we_i | input | 1 | Write enable for the upper word |
| hi_wdata_i | input | 32 | Upper word load value |
| lo_we_i | input | 1 | Write enable for the lower word |
| lo_wdata_i | input | 32 | Lower word load value |
| acc_hi_o | output | 32 | Upper accumulator word |
| acc_lo_o | output | 32 | Lower accumulator word |
| done_o | output | 1 | One-cycle pulse on write-back |

## Verification
The clash that matters is an operation's write-back landing in the same cycle as a clear or a direct word load. The bench counts the edges after an accepted start and asserts clr_i or lo_we_i in exactly the write-back cycle. It then checks that the clear or the loaded word won, that the other word took the result, and that done_o still pulsed. A second start in that same cycle is also driven, and the bench confirms that no further done pulse follows.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DW = 32;
    localparam int AW = 2 * DW;
    localparam int HW = DW / 2;

    localparam logic [DW-1:0] LONG_NEG_OR  = {{HW{1'b1}}, {HW{1'b0}}};
    localparam logic [DW-1:0] LONG_POS_AND = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [AW-1:0] WORD_MIN     = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [AW-1:0] WORD_MAX     = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WORD_MARK    = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] LO_CLAMP_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LO_CLAMP_POS = {1'b0, {(DW-1){1'b1}}};

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    typedef struct packed {
        mac_op_e       op;
        logic          sat;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } mac_cmd_t;

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } acc_t;

    // Final accumulator value from a wrapped 64-bit sum and the mode bits.
    function automatic acc_t clamp_sum(mac_op_e op, logic sat, logic [AW-1:0] sum);
        acc_t r;
        r.hi = sum[AW-1:DW];
        r.lo = sum[DW-1:0];
        if (sat) begin
            if (op == OP_LONG) begin
                if (sum[AW-1]) r.hi = r.hi | LONG_NEG_OR;
                else           r.hi = r.hi & LONG_POS_AND;
            end else begin
                if ($signed(sum) < $signed(WORD_MIN)) begin
                    r.hi = WORD_MARK;
                    r.lo = LO_CLAMP_NEG;
                end else if ($signed(sum) > $signed(WORD_MAX)) begin
                    r.hi = WORD_MARK;
                    r.lo = LO_CLAMP_POS;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
(
    input  mac_cmd_t      cmd_i,
    output logic [AW-1:0] prod_o
);

    logic [DW-1:0] opa, opb;
    logic signed [AW-1:0] xa, xb;

    always_comb begin
        if (cmd_i.op == OP_WORD) begin
            opa = {{HW{cmd_i.a[HW-1]}}, cmd_i.a[HW-1:0]};
            opb = {{HW{cmd_i.b[HW-1]}}, cmd_i.b[HW-1:0]};
        end else begin
            opa = cmd_i.a;
            opb = cmd_i.b;
        end
        xa     = {{DW{opa[DW-1]}}, opa};
        xb     = {{DW{opb[DW-1]}}, opb};
        prod_o = xa * xb;
    end

endmodule

// File: rtl/mac_sat.sv
module mac_sat
    import mac_pkg::*;
(
    input  acc_t          acc_i,
    input  logic [AW-1:0] prod_i,
    input  mac_op_e       op_i,
    input  logic          sat_i,
    output acc_t          nxt_o
);

    logic [AW-1:0] sum;

    always_comb begin
        sum   = {acc_i.hi, acc_i.lo} + prod_i;
        nxt_o = clamp_sum(op_i, sat_i, sum);
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  mac_cmd_t cmd_i,
    output mac_cmd_t cmd_o,
    output logic     fire_o,
    output logic     done_o
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    mac_cmd_t      cmd_q;

    assign fire_o = busy_q && (cnt_q == '0);
    assign cmd_o  = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire_o;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_INIT;
                    cmd_q  <= cmd_i;
                end
            end else if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: operands held while busy, whatever start_i does
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q && start_i |=> $stable(cmd_q));

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: countdown never exceeds the latency window
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> cnt_q <= CNT_INIT);

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          op_word_i,
    input  logic          sat_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          clr_i,
    input  logic          hi_we_i,
    input  logic [DW-1:0] hi_wdata_i,
    input  logic          lo_we_i,
    input  logic [DW-1:0] lo_wdata_i,
    output logic [DW-1:0] acc_hi_o,
    output logic [DW-1:0] acc_lo_o,
    output logic          done_o
);

    mac_cmd_t      cmd_in, cmd_q;
    logic          fire;
    logic [AW-1:0] prod;
    acc_t          acc_now, acc_nxt;

    logic [1:0][DW-1:0] word_v, wdata_v, res_v;
    logic [1:0]         we_v;

    always_comb begin
        cmd_in.op  = mac_op_e'(op_word_i);
        cmd_in.sat = sat_i;
        cmd_in.a   = a_i;
        cmd_in.b   = b_i;
    end

    mac_ctrl #(.LAT(LAT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmd_i   (cmd_in),
        .cmd_o   (cmd_q),
        .fire_o  (fire),
        .done_o  (done_o)
    );

    mac_mult u_mult (
        .cmd_i  (cmd_q),
        .prod_o (prod)
    );

    assign acc_now.hi = word_v[1];
    assign acc_now.lo = word_v[0];

    mac_sat u_sat (
        .acc_i  (acc_now),
        .prod_i (prod),
        .op_i   (cmd_q.op),
        .sat_i  (cmd_q.sat),
        .nxt_o  (acc_nxt)
    );

    assign we_v    = {hi_we_i, lo_we_i};
    assign wdata_v = {hi_wdata_i, lo_wdata_i};
    assign res_v   = {acc_nxt.hi, acc_nxt.lo};

    // Per-word register: clear > port write > write-back
    for (genvar w = 0; w < 2; w++) begin : g_word
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr_i)  q <= '0;
            else if (we_v[w])  q <= wdata_v[w];
            else if (fire)     q <= res_v[w];
        end
        assign word_v[w] = q;
    end

    assign acc_hi_o = word_v[1];
    assign acc_lo_o = word_v[0];

    // R8: clear zeroes both words next cycle
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_hi_o == '0) && (acc_lo_o == '0));

    // R9: direct load of the upper word
    p_hi_load_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_i && hi_we_i |=> acc_hi_o == $past(hi_wdata_i));

    // R9: direct load of the lower word
    p_lo_load_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_i && lo_we_i |=> acc_lo_o == $past(lo_wdata_i));

    // R6: accumulator holds when nothing writes it
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !clr_i && !hi_we_i && !lo_we_i && !fire |=>
            $stable(acc_hi_o) && $stable(acc_lo_o));

    // R4: saturated long result keeps the upper word in a 48-bit window
    p_long_window_r4: assert property (@(posedge clk) disable iff (rst)
        fire && !clr_i && !hi_we_i && cmd_q.op == OP_LONG && cmd_q.sat |=>
            (acc_hi_o[DW-1:HW] == {HW{1'b1}}) ||
            (acc_hi_o[DW-1:HW-1] == '0));

    // R5: saturated word result leaves upper word at 0, -1 or the mark 1
    p_word_hi_r5: assert property (@(posedge clk) disable iff (rst)
        fire && !clr_i && !hi_we_i && cmd_q.op == OP_WORD && cmd_q.sat |=>
            (acc_hi_o == '0) || (acc_hi_o == '1) || (acc_hi_o == WORD_MARK));

    // R6: done follows a write-back
    p_done_after_fire_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> done_o);

endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb;

    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, op_word_i = 1'b0, sat_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        clr_i = 1'b0, hi_we_i = 1'b0, lo_we_i = 1'b0;
    logic [31:0] hi_wdata_i = '0, lo_wdata_i = '0;
    logic [31:0] acc_hi_o, acc_lo_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    mac_unit #(.LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_word_i(op_word_i),
        .sat_i(sat_i), .a_i(a_i), .b_i(b_i), .clr_i(clr_i),
        .hi_we_i(hi_we_i), .hi_wdata_i(hi_wdata_i),
        .lo_we_i(lo_we_i), .lo_wdata_i(lo_wdata_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
    );

    typedef struct packed {
        logic        op;
        logic        sat;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] hi;
        logic [31:0] lo;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0003, 32'hFFFF_FFFE, 32'h0,           32'h0},
        '{1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0,           32'h5},
        '{1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0,           32'h0},
        '{1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0,           32'h0},
        '{1'b0, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF,   32'hFFFF_FFFF},
        '{1'b1, 1'b0, 32'h1234_FFFF, 32'hABCD_0002, 32'h0,           32'hA},
        '{1'b1, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0,           32'hFFFF_FFFF},
        '{1'b1, 1'b1, 32'h0000_7FFF, 32'h0000_7FFF, 32'h0,           32'h7FFF_FFFF},
        '{1'b1, 1'b1, 32'h0000_8000, 32'h0000_7FFF, 32'hFFFF_FFFF,   32'h8000_0000},
        '{1'b1, 1'b1, 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFF,   32'hFFFF_FFF0}
    };

    // Reference model written from the requirements
    function automatic logic [63:0] ref_mac(logic op, logic sat, logic [31:0] a,
                                            logic [31:0] b, logic [31:0] hi,
                                            logic [31:0] lo);
        longint s, p;
        logic [31:0] rh;
        s = longint'({hi, lo});
        if (op) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
        else    p = longint'(int'(a)) * longint'(int'(b));
        s = s + p;
        if (!sat) return s;
        if (!op) begin
            rh = s[63:32];
            if (s < 0) rh = rh | 32'hFFFF_0000;
            else       rh = rh & 32'h0000_7FFF;
            return {rh, s[31:0]};
        end
        if (s < -64'sd2147483648) return {32'd1, 32'h8000_0000};
        if (s >  64'sd2147483647) return {32'd1, 32'h7FFF_FFFF};
        return s;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic load(logic [31:0] hi, logic [31:0] lo);
        hi_we_i = 1'b1; hi_wdata_i = hi;
        lo_we_i = 1'b1; lo_wdata_i = lo;
        tick();
        hi_we_i = 1'b0; lo_we_i = 1'b0;
    endtask

    // Drives start and stops at the write-back cycle (before edge E+LAT)
    task automatic launch(logic op, logic sat, logic [31:0] a, logic [31:0] b);
        start_i = 1'b1; op_word_i = op; sat_i = sat; a_i = a; b_i = b;
        tick();
        start_i = 1'b0;
        repeat (LAT - 1) tick();
    endtask

    function automatic string tag_of(logic op, logic sat);
        if (op) return sat ? "R5" : "R3";
        return sat ? "R4" : "R2";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: state under reset
        check("R1", "acc in reset", {acc_hi_o, acc_lo_o}, 64'h0);
        check("R1", "done in reset", 64'(done_o), 64'h0);
        rst = 1'b0;
        tick();
        check("R1", "acc after reset", {acc_hi_o, acc_lo_o}, 64'h0);

        // Table of vectors: R2..R6
        for (int i = 0; i < NV; i++) begin
            load(VECS[i].hi, VECS[i].lo);
            launch(VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b);
            check("R6", "done early", 64'(done_o), 64'h0);
            tick();
            check("R6", "done pulse", 64'(done_o), 64'h1);
            check(tag_of(VECS[i].op, VECS[i].sat), $sformatf("vector %0d", i),
                  {acc_hi_o, acc_lo_o},
                  ref_mac(VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b,
                          VECS[i].hi, VECS[i].lo));
            tick();
            check("R6", "done falls", 64'(done_o), 64'h0);
        end

        // R2: hand value 3 * -2 from zero
        load(32'h0, 32'h0);
        launch(1'b0, 1'b0, 32'h3, 32'hFFFF_FFFE);
        tick();
        check("R2", "3*-2", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);

        // R5: hand value, word saturates above
        load(32'h0, 32'h7FFF_FFFF);
        launch(1'b1, 1'b1, 32'h0000_7FFF, 32'h0000_7FFF);
        tick();
        check("R5", "word clamp high", {acc_hi_o, acc_lo_o}, 64'h0000_0001_7FFF_FFFF);

        // R9: single-word write leaves the other word
        load(32'hAAAA_AAAA, 32'h5555_5555);
        hi_we_i = 1'b1; hi_wdata_i = 32'h1234_5678;
        tick();
        hi_we_i = 1'b0;
        check("R9", "hi-only write", {acc_hi_o, acc_lo_o}, 64'h1234_5678_5555_5555);

        // R8: plain clear
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        check("R8", "clear", {acc_hi_o, acc_lo_o}, 64'h0);

        // R7: second start while busy is ignored
        load(32'h0, 32'h0);
        start_i = 1'b1; op_word_i = 1'b0; sat_i = 1'b0; a_i = 32'd2; b_i = 32'd3;
        tick();
        a_i = 32'd100; b_i = 32'd100;
        tick();
        start_i = 1'b0;
        repeat (LAT - 2) tick();
        tick();
        check("R7", "busy start ignored", {64'(done_o), 64'(acc_lo_o)} == {64'h1, 64'd6} ? 64'h1 : 64'h0, 64'h1);

        // R7: start in write-back cycle ignored, no later done
        begin
            int pulses;
            load(32'h0, 32'h0);
            launch(1'b0, 1'b0, 32'd7, 32'd7);
            start_i = 1'b1; a_i = 32'd9; b_i = 32'd9;
            tick();
            start_i = 1'b0;
            check("R7", "result at write-back", {acc_hi_o, acc_lo_o}, 64'd49);
            pulses = 0;
            repeat (LAT + 2) begin
                tick();
                if (done_o) pulses++;
            end
            check("R7", "extra done pulses", 64'(pulses), 64'h0);
            check("R7", "acc unchanged", {acc_hi_o, acc_lo_o}, 64'd49);
        end

        // R8: clear at write-back wins, done still pulses
        load(32'h0, 32'h5);
        launch(1'b0, 1'b0, 32'd1, 32'd1);
        clr_i = 1'b1;
        tick();
        clr_i = 1'b0;
        check("R8", "clear beats write-back", {acc_hi_o, acc_lo_o}, 64'h0);
        check("R8", "done with clear", 64'(done_o), 64'h1);

        // R9: lower-word write at write-back, upper word takes result
        load(32'h7, 32'h0);
        launch(1'b0, 1'b0, 32'd5, 32'd5);
        lo_we_i = 1'b1; lo_wdata_i = 32'hDEAD_BEEF;
        tick();
        lo_we_i = 1'b0;
        check("R9", "write vs write-back", {acc_hi_o, acc_lo_o}, 64'h0000_0007_DEAD_BEEF);

        // R10: load during flight is part of the sum
        load(32'h0, 32'h0);
        start_i = 1'b1; op_word_i = 1'b1; sat_i = 1'b0; a_i = 32'd3; b_i = 32'd4;
        tick();
        start_i = 1'b0;
        lo_we_i = 1'b1; lo_wdata_i = 32'd100;
        tick();
        lo_we_i = 1'b0;
        repeat (LAT - 2) tick();
        tick();
        check("R10", "mid-flight load", {acc_hi_o, acc_lo_o}, 64'd112);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule